// File: doc/BRIEF.md
# Byte-Lane Interrupt Register Window

This block is the memory-mapped register front end of a 64-source interrupt controller. It holds four 64-bit configuration words (source mask, edge mode, message-signalled enable and input polarity) and two byte-per-source tables (a vector table and a route table). It also exposes a read-only status word built from the in-service vector that the pending core supplies. Every register is a 64-bit word at an 8-byte-aligned internal address. Accesses of 1, 2, 4 or 8 bytes land at any byte offset inside that word. Writes merge byte lanes into the word, and reads shift the word down by the offset.

Software reaches the registers through three windows chosen by `req_win`, and each window rebases addresses its own way. The low window takes 32-bit-style accesses over its first 0x100 bytes. The route window accepts single bytes and rebases onto the tables. The high window rebases onto the status word. Toward the pending core the block emits one-cycle pulses: one for the mask bits that were just cleared, one for the mask bits that were just set, and one for edge sources cleared through a write-only clear word. Each access is accepted on the cycle it is presented, and its response follows one cycle later.

Top module: `irq_regwin`

## Requirements
- R1: After reset, `cfg_mask` is all ones. `cfg_edge`, `cfg_msi_en`, `cfg_pol`, both tables, all three pulse outputs and `rsp_valid` are zero.
- R2: A read selects the word at the internal address with its low three bits cleared. The byte offset is the internal address modulo 8. `rsp_rdata` is the word shifted right by 8×offset and masked to the access size. `req_size` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R3: A write shifts the size-masked `req_wdata` left by 8×offset and replaces only the bytes the access covers. Bytes above byte 7 are dropped, and all other bytes keep their value.
- R4: On the cycle after a write to the mask word, `mask_off_pulse` holds the bits that went from 1 to 0 and `mask_on_pulse` holds the bits that went from 0 to 1. Both are zero in every other cycle.
- R5: The clear word reads as zero and changes no register. A write to it raises `clr_pulse` for one cycle with the written bits ANDed with `cfg_edge`.
- R6: The two auto-control words read as zero and ignore writes.
- R7: The status word reads as `isr_in & ~cfg_mask`, both sampled in the request cycle. Writes to it are ignored.
- R8: The route window (`req_win`=1) adds 0x100 to its address, spans 0x2a0 bytes and accepts only size code 0. Window offsets 0x000–0x03f reach route entries 0–63 and 0x100–0x13f reach vector entries 0–63. Entry i is bits [8i+7:8i] of `route_tab` / `vec_tab`.
- R9: The low window (`req_win`=0, no rebase, span 0x100) and the high window (`req_win`=2, adds 0x3a0, span 0xc60) accept size code 2 on 4-aligned addresses and size code 3 on 8-aligned addresses. The low window places the mask at 0x20, message enable at 0x40, edge at 0x60, clear at 0x80 and auto-control at 0xc0 and 0xe0. The high window places status at 0x000 and polarity at 0x040.
- R10: An access outside its window's span, with a size or alignment the window does not accept, to an undecoded address, or with `req_win`=3 reads zero and changes nothing.
- R11: `req_ready` is always 1. `rsp_valid` is high exactly one cycle after each cycle with `req_valid` high, and a write response carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Always accepting |
| req_win | input | 2 | Window: 0 low, 1 route, 2 high |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 12 | Byte address inside the window |
| req_size | input | 2 | Access size code (bytes = 2^code) |
| req_wdata | input | 64 | Write data, right-aligned |
| isr_in | input | 64 | In-service vector from the pending core |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 64 | Read data, right-aligned |
| cfg_mask | output | 64 | Source mask word |
| cfg_edge | output | 64 | Edge mode word |
| cfg_msi_en | output | 64 | Message-signalled enable word |
| cfg_pol | output | 64 | Polarity word |
| vec_tab | output | 512 | Vector table, one byte per source |
| route_tab | output | 512 | Route table, one byte per source |
| mask_off_pulse | output | 64 | Mask bits just cleared |
| mask_on_pulse | output | 64 | Mask bits just set |
| clr_pulse | output | 64 | Edge sources just cleared |

## Verification
The response, every register update and all three pulses are due on the first rising edge after the request cycle. Nothing in the block takes longer. The bench drives each request on a falling edge and removes it on the next falling edge, where it compares every output with its model. Because the pulses last one cycle, that sampling point catches each one exactly once. The status read is checked against the model's mask before the request's own write-back, since the word is built in the request cycle.

// File: rtl/irq_regwin.sv
module irq_regwin #(
  parameter int NSRC = 64,
  parameter int AW   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_win,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_size,
  input  logic [63:0]       req_wdata,
  input  logic [63:0]       isr_in,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic [63:0]       cfg_mask,
  output logic [63:0]       cfg_edge,
  output logic [63:0]       cfg_msi_en,
  output logic [63:0]       cfg_pol,
  output logic [NSRC*8-1:0] vec_tab,
  output logic [NSRC*8-1:0] route_tab,
  output logic [63:0]       mask_off_pulse,
  output logic [63:0]       mask_on_pulse,
  output logic [63:0]       clr_pulse
);
  localparam int TIDX = $clog2(NSRC);
  localparam logic [AW-1:0] LOW_SPAN   = AW'('h100);
  localparam logic [AW-1:0] ROUTE_SPAN = AW'('h2a0);
  localparam logic [AW-1:0] HIGH_SPAN  = AW'('hc60);
  localparam logic [AW-1:0] ROUTE_BASE = AW'('h100);
  localparam logic [AW-1:0] HIGH_BASE  = AW'('h3a0);
  localparam logic [AW-1:0] A_MASK  = AW'('h020);
  localparam logic [AW-1:0] A_MSIEN = AW'('h040);
  localparam logic [AW-1:0] A_EDGE  = AW'('h060);
  localparam logic [AW-1:0] A_CLR   = AW'('h080);
  localparam logic [AW-1:0] A_RT    = AW'('h100);
  localparam logic [AW-1:0] A_VT    = AW'('h200);
  localparam logic [AW-1:0] A_STAT  = AW'('h3a0);
  localparam logic [AW-1:0] A_POL   = AW'('h3e0);
  localparam logic [AW-1-TIDX:0] RT_HI = A_RT[AW-1:TIDX];
  localparam logic [AW-1-TIDX:0] VT_HI = A_VT[AW-1:TIDX];

  logic [7:0]    rt_q [NSRC];
  logic [7:0]    vt_q [NSRC];
  logic [AW-1:0] iaddr;
  logic          acc_ok, w32_ok;
  logic [2:0]    off;
  logic [63:0]   szmask, wsh, wbits, cur_word, rt_word, vt_word;
  logic [7:0]    ben;
  logic          hit_rt, hit_vt, do_wr, do_rd;
  logic          sel_mask, sel_msien, sel_edge, sel_clr, sel_stat, sel_pol;

  assign req_ready = 1'b1;

  assign w32_ok = (req_size == 2'd2 && req_addr[1:0] == 2'b00) ||
                  (req_size == 2'd3 && req_addr[2:0] == 3'b000);

  always_comb begin
    iaddr  = req_addr;
    acc_ok = 1'b0;
    case (req_win)
      2'd0: acc_ok = (req_addr < LOW_SPAN) && w32_ok;
      2'd1: begin
        iaddr  = req_addr + ROUTE_BASE;
        acc_ok = (req_addr < ROUTE_SPAN) && (req_size == 2'd0);
      end
      2'd2: begin
        iaddr  = req_addr + HIGH_BASE;
        acc_ok = (req_addr < HIGH_SPAN) && w32_ok;
      end
      default: acc_ok = 1'b0;
    endcase
  end

  assign off   = iaddr[2:0];
  assign do_wr = req_valid && req_write && acc_ok;
  assign do_rd = req_valid && !req_write && acc_ok;

  always_comb begin
    case (req_size)
      2'd0:    szmask = 64'h0000_0000_0000_00ff;
      2'd1:    szmask = 64'h0000_0000_0000_ffff;
      2'd2:    szmask = 64'h0000_0000_ffff_ffff;
      default: szmask = '1;
    endcase
  end

  assign wsh = (req_wdata & szmask) << {off, 3'b000};

  always_comb begin
    for (int k = 0; k < 8; k++) begin
      ben[k] = (k >= int'(off)) && ((k - int'(off)) < (1 << req_size));
      wbits[8*k +: 8] = {8{ben[k]}};
    end
  end

  assign sel_mask  = iaddr[AW-1:3] == A_MASK[AW-1:3];
  assign sel_msien = iaddr[AW-1:3] == A_MSIEN[AW-1:3];
  assign sel_edge  = iaddr[AW-1:3] == A_EDGE[AW-1:3];
  assign sel_clr   = iaddr[AW-1:3] == A_CLR[AW-1:3];
  assign sel_stat  = iaddr[AW-1:3] == A_STAT[AW-1:3];
  assign sel_pol   = iaddr[AW-1:3] == A_POL[AW-1:3];
  assign hit_rt    = iaddr[AW-1:TIDX] == RT_HI;
  assign hit_vt    = iaddr[AW-1:TIDX] == VT_HI;

  always_comb begin
    for (int k = 0; k < 8; k++) begin
      rt_word[8*k +: 8] = rt_q[{iaddr[TIDX-1:3], 3'(k)}];
      vt_word[8*k +: 8] = vt_q[{iaddr[TIDX-1:3], 3'(k)}];
    end
  end

  always_comb begin
    cur_word = '0;
    if (sel_mask)       cur_word = cfg_mask;
    else if (sel_msien) cur_word = cfg_msi_en;
    else if (sel_edge)  cur_word = cfg_edge;
    else if (sel_stat)  cur_word = isr_in & ~cfg_mask;
    else if (sel_pol)   cur_word = cfg_pol;
    else if (hit_rt)    cur_word = rt_word;
    else if (hit_vt)    cur_word = vt_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_mask       <= '1;
      cfg_edge       <= '0;
      cfg_msi_en     <= '0;
      cfg_pol        <= '0;
      rsp_valid      <= 1'b0;
      rsp_rdata      <= '0;
      mask_off_pulse <= '0;
      mask_on_pulse  <= '0;
      clr_pulse      <= '0;
      for (int i = 0; i < NSRC; i++) begin
        rt_q[i] <= '0;
        vt_q[i] <= '0;
      end
    end else begin
      rsp_valid      <= req_valid;
      rsp_rdata      <= do_rd ? ((cur_word >> {off, 3'b000}) & szmask) : '0;
      mask_off_pulse <= '0;
      mask_on_pulse  <= '0;
      clr_pulse      <= '0;
      if (do_wr && sel_mask) begin
        cfg_mask       <= (cfg_mask & ~wbits) | wsh;
        mask_off_pulse <= cfg_mask & ~((cfg_mask & ~wbits) | wsh);
        mask_on_pulse  <= ~cfg_mask & ((cfg_mask & ~wbits) | wsh);
      end
      if (do_wr && sel_msien) cfg_msi_en <= (cfg_msi_en & ~wbits) | wsh;
      if (do_wr && sel_edge)  cfg_edge   <= (cfg_edge & ~wbits) | wsh;
      if (do_wr && sel_pol)   cfg_pol    <= (cfg_pol & ~wbits) | wsh;
      if (do_wr && sel_clr)   clr_pulse  <= wsh & cfg_edge;
      for (int k = 0; k < 8; k++) begin
        if (do_wr && hit_rt && ben[k]) rt_q[{iaddr[TIDX-1:3], 3'(k)}] <= wsh[8*k +: 8];
        if (do_wr && hit_vt && ben[k]) vt_q[{iaddr[TIDX-1:3], 3'(k)}] <= wsh[8*k +: 8];
      end
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_tab
    assign route_tab[8*i +: 8] = rt_q[i];
    assign vec_tab[8*i +: 8]   = vt_q[i];
  end

  // R11
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R11
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R11
  wr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == 64'd0));
  // R4
  mask_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_on_pulse & mask_off_pulse) == 64'd0);
  // R4
  mask_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_on_pulse & ~cfg_mask) == 64'd0) && ((mask_off_pulse & cfg_mask) == 64'd0));
  // R4
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (mask_on_pulse == 64'd0 && mask_off_pulse == 64'd0 && clr_pulse == 64'd0));
  // R5
  clr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse & ~cfg_edge) == 64'd0);
  // R10
  bad_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_win == 2'd3) |=> (rsp_rdata == 64'd0 && $stable(cfg_mask) &&
      $stable(cfg_edge) && $stable(cfg_pol) && $stable(cfg_msi_en)));
  // R8
  route_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_win == 2'd1 && req_size != 2'd0) |=>
      (rsp_rdata == 64'd0 && $stable(route_tab) && $stable(vec_tab)));
endmodule

// File: tb/tb_irq_regwin.sv
module tb_irq_regwin;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_win = 0, req_size = 0;
  logic [11:0] req_addr = 0;
  logic [63:0] req_wdata = 0, isr_in = 0;
  logic req_ready, rsp_valid;
  logic [63:0] rsp_rdata, cfg_mask, cfg_edge, cfg_msi_en, cfg_pol;
  logic [63:0] mask_off_pulse, mask_on_pulse, clr_pulse;
  logic [511:0] vec_tab, route_tab;

  irq_regwin dut (.*);

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [63:0] m_mask, m_edge, m_msien, m_pol;
  logic [7:0]  m_rt [64];
  logic [7:0]  m_vt [64];
  logic [63:0] e_rd, e_off, e_on, e_clr;

  task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] szm(logic [1:0] s);
    return (s == 3) ? '1 : ((64'd1 << (8 << s)) - 64'd1);
  endfunction

  function automatic bit dec(logic [1:0] w, logic [11:0] a, logic [1:0] s, output logic [11:0] ia);
    bit w32;
    w32 = (s == 2 && a[1:0] == 0) || (s == 3 && a[2:0] == 0);
    ia = a;
    case (w)
      0: return a < 12'h100 && w32;
      1: begin ia = a + 12'h100; return a < 12'h2a0 && s == 0; end
      2: begin ia = a + 12'h3a0; return a < 12'hc60 && w32; end
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] mword(logic [11:0] ia);
    logic [63:0] r = '0;
    case (ia & 12'hff8)
      12'h020: r = m_mask;
      12'h040: r = m_msien;
      12'h060: r = m_edge;
      12'h3a0: r = isr_in & ~m_mask;
      12'h3e0: r = m_pol;
      default: begin
        for (int k = 0; k < 8; k++) begin
          if (ia >= 12'h100 && ia < 12'h140) r[8*k +: 8] = m_rt[(ia & 12'h38) + k];
          if (ia >= 12'h200 && ia < 12'h240) r[8*k +: 8] = m_vt[(ia & 12'h38) + k];
        end
      end
    endcase
    return r;
  endfunction

  function automatic logic [511:0] flat(bit vt);
    logic [511:0] r;
    for (int i = 0; i < 64; i++) r[8*i +: 8] = vt ? m_vt[i] : m_rt[i];
    return r;
  endfunction

  task automatic model_reset();
    m_mask = '1; m_edge = '0; m_msien = '0; m_pol = '0;
    for (int i = 0; i < 64; i++) begin m_rt[i] = 0; m_vt[i] = 0; end
  endtask

  task automatic xfer(logic [1:0] w, bit wr, logic [11:0] a, logic [1:0] s, logic [63:0] d, string tag);
    logic [11:0] ia;
    logic [63:0] bm, dsh, nw;
    bit ok;
    int o;
    @(negedge clk);
    req_valid = 1; req_win = w; req_write = wr; req_addr = a; req_size = s; req_wdata = d;
    isr_in = {$urandom, $urandom};
    ok = dec(w, a, s, ia);
    o = int'(ia[2:0]);
    bm = '0;
    for (int k = 0; k < 8; k++) if (k >= o && k - o < (1 << s)) bm[8*k +: 8] = 8'hff;
    dsh = (d & szm(s)) << (8 * o);
    e_rd = (ok && !wr) ? ((mword(ia) >> (8 * o)) & szm(s)) : '0;
    e_off = '0; e_on = '0; e_clr = '0;
    if (ok && wr) begin
      case (ia & 12'hff8)
        12'h020: begin
          nw = (m_mask & ~bm) | dsh;
          e_off = m_mask & ~nw; e_on = ~m_mask & nw; m_mask = nw;
        end
        12'h040: m_msien = (m_msien & ~bm) | dsh;
        12'h060: m_edge = (m_edge & ~bm) | dsh;
        12'h080: e_clr = dsh & m_edge;
        12'h3e0: m_pol = (m_pol & ~bm) | dsh;
        default: for (int k = 0; k < 8; k++) if (bm[8*k]) begin
          if (ia >= 12'h100 && ia < 12'h140) m_rt[(ia & 12'h38) + k] = dsh[8*k +: 8];
          if (ia >= 12'h200 && ia < 12'h240) m_vt[(ia & 12'h38) + k] = dsh[8*k +: 8];
        end
      endcase
    end
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R11 rsp_valid"}, rsp_valid, 1'b1);
    chk({tag, " R2 rdata"}, rsp_rdata, e_rd);
    chk({tag, " R4 mask_off"}, mask_off_pulse, e_off);
    chk({tag, " R4 mask_on"}, mask_on_pulse, e_on);
    chk({tag, " R5 clr"}, clr_pulse, e_clr);
    chk({tag, " R3 regs"}, {cfg_mask, cfg_edge, cfg_msi_en, cfg_pol},
        {m_mask, m_edge, m_msien, m_pol});
    chk({tag, " R8 tables"}, {route_tab ^ vec_tab}, flat(0) ^ flat(1));
    chk({tag, " R8 route_tab"}, route_tab, flat(0));
  endtask

  function automatic logic [11:0] pick_addr(logic [1:0] w);
    int r = $urandom_range(0, 9);
    logic [11:0] a;
    case (w)
      0: begin
        case ($urandom_range(0, 6))
          0: a = 12'h20; 1: a = 12'h40; 2: a = 12'h60; 3: a = 12'h80;
          4: a = 12'hc0; 5: a = 12'he0; default: a = 12'($urandom_range(0, 31) * 8);
        endcase
        if ($urandom_range(0, 1) == 1) a = a + 4;
      end
      1: a = ($urandom_range(0, 1) == 1 ? 12'h100 : 12'h000) + 12'($urandom_range(0, 63));
      default: begin
        case ($urandom_range(0, 3))
          0: a = 12'h000; 1: a = 12'h040; 2: a = 12'h020;
          default: a = 12'($urandom_range(0, 12'hc5f / 8) * 8);
        endcase
        if ($urandom_range(0, 1) == 1) a = a + 4;
      end
    endcase
    if (r == 0) a = 12'($urandom_range(0, 4095));
    if (r == 1) a = a + 12'($urandom_range(1, 3));
    return a;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset regs", {cfg_mask, cfg_edge, cfg_msi_en, cfg_pol}, {64'hffff_ffff_ffff_ffff, 192'd0});
    chk("R1 reset tables", {vec_tab, route_tab}, 1024'd0);
    chk("R1 reset pulses", {mask_off_pulse, mask_on_pulse, clr_pulse, 63'd0, rsp_valid}, 256'd0);
    chk("R11 ready", req_ready, 1'b1);

    xfer(0, 1, 12'h24, 2, 64'h0000_0000_f0f0_0001, "R4 mask upper half");
    xfer(0, 0, 12'h20, 3, 0, "R2 mask full read");
    xfer(0, 0, 12'h24, 2, 0, "R2 mask upper read");
    xfer(0, 1, 12'h20, 0, 64'h55, "R9 size0 low rejected");
    xfer(0, 1, 12'h22, 2, 64'h1234, "R9 misaligned rejected");
    xfer(0, 1, 12'h24, 3, 64'h1234, "R9 8byte misaligned rejected");
    xfer(0, 1, 12'h60, 3, 64'h00ff_0000_0000_00f0, "R3 edge write");
    xfer(0, 1, 12'h80, 3, 64'h0f0f_0f0f_0f0f_0f0f, "R5 clear edge only");
    xfer(0, 0, 12'h80, 3, 0, "R5 clear reads zero");
    xfer(0, 1, 12'hc0, 3, '1, "R6 auto write");
    xfer(0, 0, 12'he4, 2, 0, "R6 auto read");
    xfer(2, 0, 12'h000, 3, 0, "R7 status read");
    xfer(2, 1, 12'h000, 3, '1, "R7 status write ignored");
    xfer(2, 1, 12'h044, 2, 64'hdead_beef, "R9 polarity upper");
    xfer(1, 1, 12'h03f, 0, 64'h5a, "R8 route last entry");
    xfer(1, 1, 12'h100, 0, 64'ha5, "R8 vector first entry");
    xfer(1, 0, 12'h100, 0, 0, "R8 vector read");
    xfer(1, 1, 12'h010, 1, 64'hffff, "R8 route size1 rejected");
    xfer(1, 0, 12'h2a0, 0, 0, "R10 route out of span");
    xfer(0, 0, 12'h100, 2, 0, "R10 low out of span");
    xfer(3, 1, 12'h020, 3, 0, "R10 window3");
    xfer(0, 0, 12'h00, 3, 0, "R10 undecoded");

    @(negedge clk);
    chk("R11 idle no rsp", rsp_valid, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] w = 2'($urandom_range(0, 9) == 0 ? 3 : $urandom_range(0, 2));
      logic [1:0] s = (w == 1) ? ($urandom_range(0, 7) == 0 ? 2'd1 : 2'd0)
                               : 2'($urandom_range(0, 7) == 0 ? $urandom_range(0, 1) : $urandom_range(2, 3));
      xfer(w, $urandom_range(0, 1) == 1, pick_addr(w), s, {$urandom, $urandom}, "R2 R3 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule